// File: doc/BRIEF.md
# Three-Level Translation Table Walker with Status-Bit Maintenance

This block is the table-search engine behind a paged address translator. When a translation lookaside buffer misses, the requester hands the walker a virtual address together with the access kind (read or write) and the privilege (user or supervisor). The walker reads one 32-bit descriptor at each of three levels (root, pointer, page) from memory. It collects the write-protect and supervisor-only flags along the path. It returns either the physical page frame or a fault code.

While it walks, the walker keeps the used and modified flags of the descriptors current. A descriptor whose used flag is clear is re-read and written back with the flag set. The page descriptor of a write walk also gets its modified flag set, provided no protection violation was found on the path. Each such update is a locked re-read followed by a locked write, so an external arbiter cannot split it. Every memory access carries a two-bit attribute that tells the data cache how to treat it. All status updates are finished before the response is raised.

The controller is a five-state machine. `ST_IDLE` accepts a request and moves to `ST_FETCH`. `ST_FETCH` performs the plain descriptor read and then goes to one of three places: `ST_RESP` on a bad type or when the page level needs no update, `ST_LOCK_RD` when an update is needed, or back to `ST_FETCH` for the next level. `ST_LOCK_RD` performs the locked re-read and goes to `ST_LOCK_WR`. `ST_LOCK_WR` performs the locked write-back and then goes to `ST_FETCH` for the next level, or to `ST_RESP` after the page level. `ST_RESP` holds the response until it is taken and then returns to `ST_IDLE`.

Top module: `ptw_walker`

## Requirements
- R1: A fetched descriptor that has a valid type and a clear used flag (bit 2) is written back with bit 2 set. A descriptor whose bit 2 is already set causes no write, unless R2 applies to it.
- R2: On a write walk, the page descriptor is written back with the modified flag (bit 4) set when bit 4 was clear. This happens only if no write-protect flag (bit 3) and no supervisor violation was seen on the path. Otherwise bit 4 is left unchanged.
- R3: `mem_lock` is high only during the locked re-read and the locked write of an update, and it stays high continuously from the start of the one to the end of the other. Plain descriptor reads and all writes outside an update follow this rule: plain reads are unlocked, and every write is locked.
- R4: An update consists of a locked read of the same address, then a locked write of the re-read value with bit 2 set, and bit 4 set if R2 calls for it.
- R5: Plain descriptor reads carry `mem_attr` = 2'b01, meaning cacheable, write-through, no allocation on a miss.
- R6: Locked accesses carry `mem_attr` = 2'b10, meaning non-cacheable, with any matching cache line pushed and invalidated first.
- R7: The response comes only after the last bus access of the walk has completed. `mem_valid` is low while `resp_valid` is high.
- R8: The descriptor type is bits [1:0]: 0 = invalid, 1 = page, 2 = table, 3 = indirect. The root and pointer levels accept only table; the page level accepts only page. Any other type ends the walk with `resp_fault` = 1, and that descriptor is not written back.
- R9: Write-protect (bit 3) and supervisor-only (bit 5) flags are ORed across the levels. A write with any write-protect flag set, or a user access with any supervisor-only flag set, returns `resp_fault` = 2, after the R1 updates of all levels are done.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we`, `mem_wdata`, `mem_lock` and `mem_attr` do not change.
- R11: `req_ready` is low from the cycle after a request is accepted until the response has been taken. `resp_valid` stays high until `resp_ready` is seen.
- R12: Descriptor addresses follow the fields of the virtual address. The root address is `root_base` + 4·VA[31:25]. The pointer address is the table base + 4·VA[24:18], and the page address is the table base + 4·VA[17:12]. A table base is the descriptor's bits [31:9] with nine zero bits below them. On success, `resp_frame` is the page descriptor's bits [31:12] and `resp_fault` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_super | input | 1 | Access is made at supervisor privilege |
| root_base | input | 32 | Base address of the root table |
| resp_valid | output | 1 | Walk result present |
| resp_ready | input | 1 | Requester takes the result |
| resp_frame | output | 20 | Physical page frame number |
| resp_fault | output | 2 | 0 none, 1 invalid descriptor, 2 protection |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_addr | output | 32 | Descriptor address |
| mem_we | output | 1 | Access is a write |
| mem_wdata | output | 32 | Descriptor value to write |
| mem_rdata | input | 32 | Descriptor value read |
| mem_lock | output | 1 | Bus lock for a read-modify-write update |
| mem_attr | output | 2 | Cache treatment: 1 write-through no-allocate, 2 non-cacheable with push |

## Verification
Most internal faults show up within one bus access as a difference in the access stream. A wrong level counter or table base gives a wrong `mem_addr` on the very next descriptor read. A state that skips or repeats an update shows up as a missing, extra or unlocked access at that level. A wrong flag accumulator is different: it stays hidden until the page level, where it shows up as a wrong modified bit in the written data, or as a wrong fault code one response later. The bench therefore predicts the full ordered stream of bus accesses and responses for each walk and compares them entry by entry. Its walks cover fresh tables, tables that are already marked, write-protected and supervisor-only paths, every bad type, and a stalled response.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Descriptor type field, bits [1:0]
    typedef enum logic [1:0] {
        DT_INVALID  = 2'd0,
        DT_PAGE     = 2'd1,
        DT_TABLE    = 2'd2,
        DT_INDIRECT = 2'd3
    } dtype_t;

    // Flag positions inside a descriptor
    localparam int USED_POS  = 2;
    localparam int WPROT_POS = 3;
    localparam int MOD_POS   = 4;
    localparam int SUPER_POS = 5;

    // Cache treatment attribute on the memory bus
    typedef enum logic [1:0] {
        ATTR_NONE       = 2'd0,
        ATTR_WT_NOALLOC = 2'd1,
        ATTR_NC_PUSH    = 2'd2
    } attr_t;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_PROT    = 2'd2
    } fault_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOCK_RD,
        ST_LOCK_WR,
        ST_RESP
    } state_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VA_W  = 32,
    parameter int OFS_W = 12,
    parameter int L0_W  = 7,
    parameter int L1_W  = 7,
    parameter int L2_W  = 6
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [VA_W-1:0] base,
    input  logic [1:0]      level,
    output logic [VA_W-1:0] daddr
);
    localparam int LOW [3] = '{OFS_W + L2_W + L1_W, OFS_W + L2_W, OFS_W};
    localparam int WID [3] = '{L0_W, L1_W, L2_W};

    logic [VA_W-1:0] idx [3];
    logic [VA_W-1:0] sel;

    for (genvar g = 0; g < 3; g++) begin : g_lvl
        localparam logic [VA_W-1:0] MASK = (VA_W'(1) << WID[g]) - VA_W'(1);
        assign idx[g] = (vaddr >> LOW[g]) & MASK;
    end

    always_comb begin
        unique case (level)
            2'd0:    sel = idx[0];
            2'd1:    sel = idx[1];
            default: sel = idx[2];
        endcase
        daddr = base + (sel << 2);
    end
endmodule

// File: rtl/ptw_desc_eval.sv
module ptw_desc_eval
    import ptw_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] desc,
    input  logic          last_level,
    input  logic          acc_w,
    input  logic          acc_s,
    input  logic          is_write,
    input  logic          is_super,
    output logic          type_ok,
    output logic          w_next,
    output logic          s_next,
    output logic          need_u,
    output logic          need_m
);
    dtype_t dtype;
    logic   viol;
    logic   unused_hi;

    assign unused_hi = &{1'b0, desc[DW-1:SUPER_POS+1]};

    always_comb begin
        dtype   = dtype_t'(desc[1:0]);
        type_ok = last_level ? (dtype == DT_PAGE) : (dtype == DT_TABLE);
        w_next  = acc_w | desc[WPROT_POS];
        s_next  = acc_s | desc[SUPER_POS];
        viol    = (is_write && w_next) || (!is_super && s_next);
        need_u  = type_ok && !desc[USED_POS];
        need_m  = type_ok && last_level && is_write && !desc[MOD_POS] && !viol;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFS_W = 12,
    parameter int L0_W  = 7,
    parameter int L1_W  = 7,
    parameter int L2_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic                req_write,
    input  logic                req_super,
    input  logic [VA_W-1:0]     root_base,
    output logic                resp_valid,
    input  logic                resp_ready,
    output logic [VA_W-OFS_W-1:0] resp_frame,
    output logic [1:0]          resp_fault,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [VA_W-1:0]     mem_addr,
    output logic                mem_we,
    output logic [VA_W-1:0]     mem_wdata,
    input  logic [VA_W-1:0]     mem_rdata,
    output logic                mem_lock,
    output logic [1:0]          mem_attr
);
    localparam int FRAME_W   = VA_W - OFS_W;
    localparam int IDX_MAX   = (L0_W > L1_W) ? ((L0_W > L2_W) ? L0_W : L2_W)
                                             : ((L1_W > L2_W) ? L1_W : L2_W);
    localparam int TBL_SHIFT = IDX_MAX + 2;
    localparam logic [1:0] LAST_LVL = 2'd2;

    state_t              state, state_d;
    logic [1:0]          level;
    logic [VA_W-1:0]     base_q, vaddr_q, wb_q;
    logic                write_q, super_q, acc_w, acc_s, upd_m;
    fault_t              fault_q;
    logic [FRAME_W-1:0]  frame_q;

    logic                last, ev_ok, ev_w, ev_s, ev_nu, ev_nm;
    logic                step_fire, prot_now;
    logic [VA_W-1:0]     adv_desc;
    logic                unused_lo;

    assign last = (level == LAST_LVL);

    ptw_addr_gen #(
        .VA_W(VA_W), .OFS_W(OFS_W), .L0_W(L0_W), .L1_W(L1_W), .L2_W(L2_W)
    ) u_addr (
        .vaddr(vaddr_q), .base(base_q), .level(level), .daddr(mem_addr)
    );

    ptw_desc_eval #(.DW(VA_W)) u_eval (
        .desc(mem_rdata), .last_level(last), .acc_w(acc_w), .acc_s(acc_s),
        .is_write(write_q), .is_super(super_q), .type_ok(ev_ok),
        .w_next(ev_w), .s_next(ev_s), .need_u(ev_nu), .need_m(ev_nm)
    );

    // Step to next level or finish: from a fetch needing no update, or after a write-back
    always_comb begin
        adv_desc  = (state == ST_FETCH) ? mem_rdata : wb_q;
        prot_now  = (state == ST_FETCH)
                  ? ((write_q && ev_w) || (!super_q && ev_s))
                  : ((write_q && acc_w) || (!super_q && acc_s));
        step_fire = (state == ST_FETCH && mem_ready && ev_ok && !(ev_nu || ev_nm))
                 || (state == ST_LOCK_WR && mem_ready);
    end
    assign unused_lo = &{1'b0, adv_desc[TBL_SHIFT-1:0]};

    // Next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_d = ST_FETCH;
            ST_FETCH:   if (mem_ready) begin
                            if (!ev_ok)             state_d = ST_RESP;
                            else if (ev_nu || ev_nm) state_d = ST_LOCK_RD;
                            else if (last)          state_d = ST_RESP;
                            else                    state_d = ST_FETCH;
                        end
            ST_LOCK_RD: if (mem_ready) state_d = ST_LOCK_WR;
            ST_LOCK_WR: if (mem_ready) state_d = last ? ST_RESP : ST_FETCH;
            ST_RESP:    if (resp_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= '0;
            base_q  <= '0;
            vaddr_q <= '0;
            wb_q    <= '0;
            write_q <= 1'b0;
            super_q <= 1'b0;
            acc_w   <= 1'b0;
            acc_s   <= 1'b0;
            upd_m   <= 1'b0;
            fault_q <= FLT_NONE;
            frame_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    write_q <= req_write;
                    super_q <= req_super;
                    base_q  <= root_base;
                    level   <= '0;
                    acc_w   <= 1'b0;
                    acc_s   <= 1'b0;
                    fault_q <= FLT_NONE;
                    frame_q <= '0;
                end
                ST_FETCH: if (mem_ready) begin
                    wb_q <= mem_rdata;
                    if (!ev_ok) begin
                        fault_q <= FLT_INVALID;
                    end else begin
                        acc_w <= ev_w;
                        acc_s <= ev_s;
                        upd_m <= ev_nm;
                    end
                end
                ST_LOCK_RD: if (mem_ready) begin
                    wb_q <= mem_rdata
                          | (VA_W'(1) << USED_POS)
                          | (upd_m ? (VA_W'(1) << MOD_POS) : '0);
                end
                default: ;
            endcase
            if (step_fire) begin
                if (last) begin
                    frame_q <= adv_desc[VA_W-1:OFS_W];
                    fault_q <= prot_now ? FLT_PROT : FLT_NONE;
                end else begin
                    base_q <= {adv_desc[VA_W-1:TBL_SHIFT], {TBL_SHIFT{1'b0}}};
                    level  <= level + 2'd1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        mem_valid  = 1'b0;
        mem_we     = 1'b0;
        mem_lock   = 1'b0;
        mem_attr   = ATTR_NONE;
        unique case (state)
            ST_IDLE:    req_ready = 1'b1;
            ST_FETCH:   begin mem_valid = 1'b1; mem_attr = ATTR_WT_NOALLOC; end
            ST_LOCK_RD: begin mem_valid = 1'b1; mem_lock = 1'b1; mem_attr = ATTR_NC_PUSH; end
            ST_LOCK_WR: begin mem_valid = 1'b1; mem_lock = 1'b1; mem_we = 1'b1;
                              mem_attr = ATTR_NC_PUSH; end
            ST_RESP:    resp_valid = 1'b1;
            default: ;
        endcase
    end
    assign mem_wdata  = wb_q;
    assign resp_frame = frame_q;
    assign resp_fault = fault_q;

    // Assertions
    assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
        && $stable(mem_wdata) && $stable(mem_lock) && $stable(mem_attr));
    assert_write_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> mem_lock);
    assert_unlock_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> $past(mem_valid && mem_we && mem_ready));
    assert_lock_starts_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_lock) |-> mem_valid && !mem_we);
    assert_wb_sets_used_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> mem_wdata[USED_POS]);
    assert_plain_attr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_lock |-> mem_attr == ATTR_WT_NOALLOC);
    assert_locked_attr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_lock |-> mem_attr == ATTR_NC_PUSH);
    assert_resp_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !mem_valid && !mem_lock);
    assert_resp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_ready |=> resp_valid && $stable(resp_fault) && $stable(resp_frame));
    assert_single_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid || mem_valid) |-> !req_ready);
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    localparam logic [31:0] ROOT = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready, resp_valid;
    logic        resp_ready = 1'b1;
    logic [19:0] resp_frame;
    logic [1:0]  resp_fault;
    logic        mem_valid, mem_we, mem_lock;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  mem_attr;

    always #5 clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_super(req_super),
        .root_base(ROOT), .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_frame(resp_frame), .resp_fault(resp_fault), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_lock(mem_lock),
        .mem_attr(mem_attr)
    );

    typedef struct {
        bit          is_resp;
        logic [31:0] addr;
        bit          we;
        logic [31:0] wdata;
        bit          lock;
        logic [1:0]  attr;
        logic [19:0] frame;
        logic [1:0]  fault;
    } item_t;

    item_t       exp_q[$];
    logic [31:0] mem    [int unsigned];
    logic [31:0] shadow [int unsigned];
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] dsc(input logic [31:0] a, input logic [1:0] ty,
                                        input bit u, input bit w, input bit m, input bit s);
        return {a[31:6], s, m, w, u, ty};
    endfunction

    function automatic logic [31:0] mkva(input int r, input int p, input int g);
        return {7'(r), 7'(p), 6'(g), 12'h123};
    endfunction

    function automatic logic [31:0] sh_rd(input logic [31:0] a);
        return shadow.exists(a) ? shadow[a] : 32'h0;
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        mem[a] = d;
        shadow[a] = d;
    endtask

    task automatic setup3(input logic [31:0] va, input logic [31:0] rd, input logic [31:0] pd,
                          input logic [31:0] gd);
        put(ROOT + {23'd0, va[31:25], 2'b00}, rd);
        put({rd[31:9], 9'd0} + {23'd0, va[24:18], 2'b00}, pd);
        put({pd[31:9], 9'd0} + {24'd0, va[17:12], 2'b00}, gd);
    endtask

    function automatic item_t bus_it(input logic [31:0] a, input bit we, input logic [31:0] wd,
                                     input bit lk);
        item_t it;
        it.is_resp = 0; it.addr = a; it.we = we; it.wdata = wd; it.lock = lk;
        it.attr = lk ? 2'd2 : 2'd1; it.frame = '0; it.fault = '0;
        return it;
    endfunction

    // Reference model built from the requirements
    task automatic predict(input logic [31:0] va, input bit wr, input bit sup);
        logic [31:0] base;
        bit aw, as_;
        item_t rit;
        base = ROOT; aw = 0; as_ = 0;
        rit.is_resp = 1; rit.addr = '0; rit.we = 0; rit.wdata = '0; rit.lock = 0; rit.attr = '0;
        for (int l = 0; l < 3; l++) begin
            logic [31:0] idx, a, d, nd;
            bit ok, viol, nu, nm;
            idx = (l == 0) ? {25'd0, va[31:25]} : (l == 1) ? {25'd0, va[24:18]} : {26'd0, va[17:12]};
            a = base + (idx << 2);
            d = sh_rd(a);
            exp_q.push_back(bus_it(a, 0, '0, 0));
            ok = (l == 2) ? (d[1:0] == 2'd1) : (d[1:0] == 2'd2);
            if (!ok) begin
                rit.frame = '0; rit.fault = 2'd1;
                exp_q.push_back(rit);
                return;
            end
            aw  = aw | d[3];
            as_ = as_ | d[5];
            viol = (wr && aw) || (!sup && as_);
            nu = !d[2];
            nm = (l == 2) && wr && !d[4] && !viol;
            if (nu || nm) begin
                nd = d | 32'h4 | (nm ? 32'h10 : 32'h0);
                exp_q.push_back(bus_it(a, 0, '0, 1));
                exp_q.push_back(bus_it(a, 1, nd, 1));
                shadow[a] = nd;
                d = nd;
            end
            if (l == 2) begin
                rit.frame = d[31:12]; rit.fault = viol ? 2'd2 : 2'd0;
                exp_q.push_back(rit);
            end else begin
                base = {d[31:9], 9'd0};
            end
        end
    endtask

    // Memory model and scoreboard monitor
    logic [31:0] cap_addr, cap_wdata, first_addr;
    logic        cap_we, cap_lock;
    logic [1:0]  cap_attr;
    bit          seen = 0;
    int          wait_cnt = 0, delay = 0, txn_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_ready) begin
                item_t e;
                mem_ready = 1'b0;
                seen = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R7 unexpected bus access", cap_addr, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(!e.is_resp, "R7 bus access where response expected", cap_addr, 32'h0);
                    if (!e.is_resp) begin
                        check(cap_addr == e.addr, "R12 descriptor address", cap_addr, e.addr);
                        check(cap_lock == e.lock, "R3 lock", {31'd0, cap_lock}, {31'd0, e.lock});
                        check(cap_attr == e.attr, e.lock ? "R6 attribute" : "R5 attribute",
                              {30'd0, cap_attr}, {30'd0, e.attr});
                        check(cap_we == e.we, "R4 access direction", {31'd0, cap_we}, {31'd0, e.we});
                        if (e.we)
                            check(cap_wdata == e.wdata, "R1/R2 written descriptor", cap_wdata, e.wdata);
                    end
                end
            end else if (mem_valid) begin
                if (!seen) begin
                    seen = 1; first_addr = mem_addr; wait_cnt = 0; delay = txn_n % 3;
                end
                if (wait_cnt >= delay) begin
                    check(mem_addr == first_addr, "R10 address held", mem_addr, first_addr);
                    cap_addr = mem_addr; cap_we = mem_we; cap_wdata = mem_wdata;
                    cap_lock = mem_lock; cap_attr = mem_attr;
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                    mem_ready = 1'b1;
                    txn_n++;
                end else begin
                    wait_cnt++;
                end
            end
            if (resp_valid && resp_ready) begin
                item_t e;
                if (exp_q.size() == 0) begin
                    check(0, "R7 unexpected response", {30'd0, resp_fault}, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(e.is_resp, "R7 response before walk finished", {30'd0, resp_fault}, 32'h0);
                    if (e.is_resp) begin
                        check(resp_fault == e.fault, "R8/R9 fault code",
                              {30'd0, resp_fault}, {30'd0, e.fault});
                        if (e.fault == 2'd0)
                            check(resp_frame == e.frame, "R12 page frame",
                                  {12'd0, resp_frame}, {12'd0, e.frame});
                    end
                end
            end
        end
    end

    task automatic run_walk(input logic [31:0] va, input bit wr, input bit sup, input bit stall);
        predict(va, wr, sup);
        @(posedge clk); #1;
        req_vaddr = va; req_write = wr; req_super = sup; req_valid = 1'b1;
        if (stall) resp_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        check(!req_ready, "R11 busy after accept", {31'd0, req_ready}, 32'h0);
        if (stall) begin
            while (!resp_valid) @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(resp_valid && !req_ready, "R11 response held while stalled",
                      {30'd0, resp_valid, req_ready}, 32'h2);
            end
            @(posedge clk); #1;
            resp_ready = 1'b1;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(req_ready && !resp_valid, "R11 idle after response",
              {30'd0, req_ready, resp_valid}, 32'h2);
    endtask

    initial begin
        logic [31:0] va1, va2, va3, va4, va5, va6;
        va1 = mkva(3, 5, 7);   va2 = mkva(10, 1, 2); va3 = mkva(11, 2, 3);
        va4 = mkva(12, 4, 4);  va5 = mkva(13, 0, 0); va6 = mkva(14, 1, 1);
        // R12: fresh tables, no flags set
        setup3(va1, dsc(32'h0002_0000, 2, 0, 0, 0, 0), dsc(32'h0003_0000, 2, 0, 0, 0, 0),
               dsc(32'h0ABC_D000, 1, 0, 0, 0, 0));
        // R9: write-protect at root
        setup3(va2, dsc(32'h0002_0200, 2, 1, 1, 0, 0), dsc(32'h0003_0200, 2, 0, 0, 0, 0),
               dsc(32'h0123_4000, 1, 0, 0, 0, 0));
        // R9: supervisor-only page, all used flags set
        setup3(va3, dsc(32'h0002_0400, 2, 1, 0, 0, 0), dsc(32'h0003_0400, 2, 1, 0, 0, 0),
               dsc(32'h0555_5000, 1, 1, 0, 0, 1));
        // R8: invalid pointer descriptor
        setup3(va4, dsc(32'h0002_0600, 2, 0, 0, 0, 0), dsc(32'h0003_0600, 0, 0, 0, 0, 0),
               dsc(32'h0777_7000, 1, 0, 0, 0, 0));
        // R8: page type at root level
        put(ROOT + {23'd0, va5[31:25], 2'b00}, dsc(32'h0002_0800, 1, 0, 0, 0, 0));
        // R8: indirect type at page level
        setup3(va6, dsc(32'h0002_0A00, 2, 1, 0, 0, 0), dsc(32'h0003_0A00, 2, 1, 0, 0, 0),
               dsc(32'h0999_9000, 3, 0, 0, 0, 0));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !resp_valid && !mem_valid && !mem_lock, "R11 reset state",
              {28'd0, req_ready, resp_valid, mem_valid, mem_lock}, 32'h8);

        run_walk(va1, 0, 0, 0);   // R1: three locked used-flag updates
        run_walk(va1, 0, 0, 0);   // R1: flags now set, plain reads only
        run_walk(va1, 1, 0, 0);   // R2: modified flag set on the page
        run_walk(va1, 1, 0, 0);   // R2: already modified, no update
        run_walk(va2, 1, 0, 0);   // R9: write-protected, modified suppressed
        run_walk(va2, 0, 0, 0);   // R9: read through write-protect succeeds
        run_walk(va3, 0, 0, 0);   // R9: user access to supervisor page
        run_walk(va3, 1, 1, 0);   // R2: supervisor write sets modified
        run_walk(va4, 0, 1, 0);   // R8: invalid pointer descriptor
        run_walk(va5, 0, 1, 0);   // R8: wrong type at root
        run_walk(va6, 1, 1, 0);   // R8: indirect type at page level
        run_walk(va1, 0, 1, 1);   // R11: stalled response

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R7 walk did not complete actual=%0d expected=0", exp_q.size());
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule